// File: doc/BRIEF.md
# Configurable Macrocell Output Register

This block is the storage stage at the end of one programmable-logic cell. A vector of product terms is ORed and then XORed with a polarity term to form the cell's sum term. A set of static configuration inputs then shapes how that sum term reaches the output. The register can act as a D, T, JK or SR flip-flop, or it can be bypassed so that the sum term goes straight to the output.

The register is clocked by one of three sources. The first is a selected global clock, which may be inverted. The second is that same clock qualified by an active-high enable. The third is a clock formed from a product term. Two product terms give a preset and a clear that act at once, ahead of any clock. A separate active-low global clear can be connected to the cell one cell at a time.

The emulated clock sources are plain level inputs, sampled on the system clock `clk`. A low-to-high change of the selected source counts as one edge. The block is meant to be placed many times in a fabric whose configuration stays fixed while it runs.

Top module: `mcell_reg_stage`

## Requirements
- R1: The sum term is (OR of all bits of `pt_sum`) XOR `pt_pol`. When `cfg_ff_kind` is 4 to 7 (bypass), `mc_out` equals the sum term in the same cycle. The hidden register keeps following its clock while bypassed.
- R2: With `cfg_ff_kind`=0 (D), a counted edge loads the sum term into the register.
- R3: With `cfg_ff_kind`=1 (T), a counted edge inverts the register when the sum term is 1 and leaves it unchanged when the sum term is 0.
- R4: With `cfg_ff_kind`=2 (JK), J is the sum term and K is `pt_k`. On a counted edge: 00 holds, 10 sets, 01 clears, 11 toggles.
- R5: With `cfg_ff_kind`=3 (SR), S is the sum term and R is `pt_k`. On a counted edge: 00 holds, 10 sets, 01 clears, 11 holds.
- R6: In clock modes 0 and 3, an edge is a rise of the selected global clock. In mode 1, that rise counts only if `gce` is 1 in the same cycle. A rise with `gce`=0 is consumed and is lost.
- R7: In clock mode 2, the edge is a rise of `pt_clk`. Both `gce` and the global clocks have no effect.
- R8: The global clock is `gclk[cfg_gclk_sel]` XOR `cfg_gclk_inv`. With inversion set, a high-to-low change of the pin counts as the edge.
- R9: While `pt_pre` is 1 and no clear is active, a registered `mc_out` is 1 in the same cycle, and the register holds 1 after the next `clk` edge.
- R10: `pt_clr`=1, or `gclr_n`=0 with `cfg_gclr_en`=1, forces a registered `mc_out` to 0 at once and clears the register. A clear wins over a preset.
- R11: Reset clears the register. Right after reset, a source that is already high gives no edge until it has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all emulated clock sources |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ff_kind | input | 3 | 0 D, 1 T, 2 JK, 3 SR, 4-7 bypass |
| cfg_clk_mode | input | 2 | 0 global, 1 global with enable, 2 product-term clock, 3 same as 0 |
| cfg_gclk_sel | input | SEL_W | Index of the global clock pin in use |
| cfg_gclk_inv | input | 1 | Use the complement of the selected global clock |
| cfg_gclr_en | input | 1 | Connect the global clear to this cell |
| pt_sum | input | NUM_PT | Product terms ORed into the sum term |
| pt_pol | input | 1 | Polarity term XORed with the OR result |
| pt_k | input | 1 | Second data term (K or R) |
| pt_clk | input | 1 | Product-term clock source |
| pt_pre | input | 1 | Product-term preset, active high |
| pt_clr | input | 1 | Product-term clear, active high |
| gclk | input | NUM_GCLK | Global clock pins, sampled as levels |
| gce | input | 1 | Global clock enable, active high |
| gclr_n | input | 1 | Global clear, active low |
| mc_out | output | 1 | Cell output |

## Verification
The bench targets the cases where a small slip changes the stored state without any visible fault. These are:
- JK with both inputs high, which would hold instead of toggling.
- SR with both inputs high, which would flip or force a value instead of holding.
- An enabled-clock rise with the enable low, which would load data.
- An inverted global clock, which would fire on the wrong pin transition.
- Preset and clear asserted together, where preset winning would show a 1.
- A source that is already high as reset ends, which would give a spurious load in the first cycle.

It also covers a bypassed cell whose register moves underneath. Returning to registered mode then exposes a state that failed to track.

// File: rtl/mcell_pkg.sv
`timescale 1ns/1ps
package mcell_pkg;

  typedef enum logic [2:0] {
    FF_D   = 3'd0,
    FF_T   = 3'd1,
    FF_JK  = 3'd2,
    FF_SR  = 3'd3,
    FF_BYP = 3'd4
  } ff_kind_e;

  typedef enum logic [1:0] {
    CK_GLB     = 2'd0,
    CK_GLB_CE  = 2'd1,
    CK_ARR     = 2'd2,
    CK_GLB_ALT = 2'd3
  } ck_mode_e;

  // any kind code at or above the bypass code is treated as bypass
  function automatic logic kind_is_bypass(logic [2:0] kind);
    return kind >= FF_BYP;
  endfunction

endpackage

// File: rtl/mcell_rst_sync.sv
`timescale 1ns/1ps
module mcell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mcell_sum_term.sv
`timescale 1ns/1ps
module mcell_sum_term #(
  parameter int NUM_PT = 5
) (
  input  logic [NUM_PT-1:0] pt_sum,
  input  logic              pt_pol,
  output logic              sum_o
);
  logic [NUM_PT-1:0] or_chain;

  // ripple OR written out so the width follows the parameter
  generate
    for (genvar g = 0; g < NUM_PT; g++) begin : g_or
      if (g == 0) begin : g_first
        assign or_chain[g] = pt_sum[g];
      end else begin : g_rest
        assign or_chain[g] = or_chain[g-1] | pt_sum[g];
      end
    end
  endgenerate

  assign sum_o = or_chain[NUM_PT-1] ^ pt_pol;
endmodule

// File: rtl/mcell_clk_pick.sv
`timescale 1ns/1ps
module mcell_clk_pick
  import mcell_pkg::*;
#(
  parameter int NUM_GCLK = 2,
  parameter int SEL_W    = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [SEL_W-1:0]    gclk_sel,
  input  logic                gclk_inv,
  input  logic                pt_clk,
  input  logic                gce,
  input  logic [1:0]          mode,
  output logic                tick_o
);
  logic glb_lvl;
  logic src_lvl;
  logic qual;
  logic prev_q;
  logic prev_d;

  always_comb begin
    glb_lvl = 1'b0;
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (gclk_sel == SEL_W'(i)) glb_lvl = gclk[i];
    end
    glb_lvl = glb_lvl ^ gclk_inv;
  end

  always_comb begin
    src_lvl = (mode == CK_ARR) ? pt_clk : glb_lvl;
    qual    = (mode == CK_GLB_CE) ? gce : 1'b1;
    prev_d  = src_lvl;
    tick_o  = src_lvl & ~prev_q & qual;
  end

  // reset high: a source already high at release is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/mcell_ff_next.sv
`timescale 1ns/1ps
module mcell_ff_next
  import mcell_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       q,
  input  logic       in_a,
  input  logic       in_b,
  output logic       nxt_o
);
  always_comb begin
    case (kind)
      FF_T:    nxt_o = q ^ in_a;
      FF_JK: begin
        case ({in_a, in_b})
          2'b10:   nxt_o = 1'b1;
          2'b01:   nxt_o = 1'b0;
          2'b11:   nxt_o = ~q;
          default: nxt_o = q;
        endcase
      end
      FF_SR: begin
        case ({in_a, in_b})
          2'b10:   nxt_o = 1'b1;
          2'b01:   nxt_o = 1'b0;
          default: nxt_o = q;
        endcase
      end
      default: nxt_o = in_a;
    endcase
  end
endmodule

// File: rtl/mcell_reg_stage.sv
`timescale 1ns/1ps
module mcell_reg_stage
  import mcell_pkg::*;
#(
  parameter int NUM_PT   = 5,
  parameter int NUM_GCLK = 2,
  localparam int SEL_W   = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cfg_ff_kind,
  input  logic [1:0]          cfg_clk_mode,
  input  logic [SEL_W-1:0]    cfg_gclk_sel,
  input  logic                cfg_gclk_inv,
  input  logic                cfg_gclr_en,
  input  logic [NUM_PT-1:0]   pt_sum,
  input  logic                pt_pol,
  input  logic                pt_k,
  input  logic                pt_clk,
  input  logic                pt_pre,
  input  logic                pt_clr,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                gce,
  input  logic                gclr_n,
  output logic                mc_out
);
  logic rst_sync_n;
  logic sum_term;
  logic tick;
  logic ff_nxt;
  logic clr_any;
  logic q_reg;
  logic q_d;
  logic q_view;

  mcell_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mcell_sum_term #(.NUM_PT(NUM_PT)) u_sum (
    .pt_sum (pt_sum),
    .pt_pol (pt_pol),
    .sum_o  (sum_term)
  );

  mcell_clk_pick #(.NUM_GCLK(NUM_GCLK), .SEL_W(SEL_W)) u_ck (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .gclk     (gclk),
    .gclk_sel (cfg_gclk_sel),
    .gclk_inv (cfg_gclk_inv),
    .pt_clk   (pt_clk),
    .gce      (gce),
    .mode     (cfg_clk_mode),
    .tick_o   (tick)
  );

  mcell_ff_next u_nxt (
    .kind  (cfg_ff_kind),
    .q     (q_reg),
    .in_a  (sum_term),
    .in_b  (pt_k),
    .nxt_o (ff_nxt)
  );

  // next state: clear over preset over clocked update
  always_comb begin
    clr_any = pt_clr | (cfg_gclr_en & ~gclr_n);
    if (clr_any)     q_d = 1'b0;
    else if (pt_pre) q_d = 1'b1;
    else if (tick)   q_d = ff_nxt;
    else             q_d = q_reg;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) q_reg <= 1'b0;
    else             q_reg <= q_d;
  end

  // preset and clear reach the output without waiting for a clock
  always_comb begin
    if (clr_any)     q_view = 1'b0;
    else if (pt_pre) q_view = 1'b1;
    else             q_view = q_reg;
    mc_out = kind_is_bypass(cfg_ff_kind) ? sum_term : q_view;
  end
endmodule

// File: rtl/mcell_reg_stage_chk.sv
`timescale 1ns/1ps
module mcell_reg_stage_chk #(
  parameter int NUM_PT = 5
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [2:0]        cfg_ff_kind,
  input logic [1:0]        cfg_clk_mode,
  input logic              cfg_gclr_en,
  input logic [NUM_PT-1:0] pt_sum,
  input logic              pt_pol,
  input logic              pt_pre,
  input logic              pt_clr,
  input logic              gce,
  input logic              gclr_n,
  input logic              q_reg,
  input logic              mc_out
);
  logic byp;
  logic clr_in;
  assign byp    = cfg_ff_kind >= 3'd4;
  assign clr_in = pt_clr | (cfg_gclr_en & ~gclr_n);

  a_r1_bypass_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byp |-> (mc_out == ((|pt_sum) ^ pt_pol)));

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!byp && clr_in) |-> !mc_out);

  a_r10_reg_cleared: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_in |=> !q_reg);

  a_r9_preset_out: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!byp && !clr_in && pt_pre) |-> mc_out);

  a_r9_reg_preset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_in && pt_pre) |=> q_reg);

  a_r6_enable_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_clk_mode == 2'd1 && !gce && !pt_pre && !clr_in) |=> $stable(q_reg));

  a_r11_reset_zero: assert property (@(posedge clk)
    !rst_sync_n |-> !q_reg);
endmodule

bind mcell_reg_stage mcell_reg_stage_chk #(.NUM_PT(NUM_PT)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cfg_ff_kind  (cfg_ff_kind),
  .cfg_clk_mode (cfg_clk_mode),
  .cfg_gclr_en  (cfg_gclr_en),
  .pt_sum       (pt_sum),
  .pt_pol       (pt_pol),
  .pt_pre       (pt_pre),
  .pt_clr       (pt_clr),
  .gce          (gce),
  .gclr_n       (gclr_n),
  .q_reg        (q_reg),
  .mc_out       (mc_out)
);

// File: tb/mcell_reg_stage_tb.sv
`timescale 1ns/1ps
module mcell_reg_stage_tb_top;
  localparam int NUM_PT = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic [2:0]        cfg_ff_kind = 3'd0;
  logic [1:0]        cfg_clk_mode = 2'd0;
  logic [0:0]        cfg_gclk_sel = 1'b0;
  logic              cfg_gclk_inv = 1'b0;
  logic              cfg_gclr_en = 1'b1;
  logic [NUM_PT-1:0] pt_sum = '0;
  logic              pt_pol = 1'b0;
  logic              pt_k = 1'b0;
  logic              pt_clk = 1'b0;
  logic              pt_pre = 1'b0;
  logic              pt_clr = 1'b0;
  logic [1:0]        gclk = 2'b11;
  logic              gce = 1'b0;
  logic              gclr_n = 1'b1;
  logic              mc_out;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;
  logic r_q;
  logic r_prev;

  always #10 clk = ~clk;

  mcell_reg_stage #(.NUM_PT(NUM_PT), .NUM_GCLK(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ff_kind(cfg_ff_kind), .cfg_clk_mode(cfg_clk_mode),
    .cfg_gclk_sel(cfg_gclk_sel), .cfg_gclk_inv(cfg_gclk_inv), .cfg_gclr_en(cfg_gclr_en),
    .pt_sum(pt_sum), .pt_pol(pt_pol), .pt_k(pt_k), .pt_clk(pt_clk), .pt_pre(pt_pre),
    .pt_clr(pt_clr), .gclk(gclk), .gce(gce), .gclr_n(gclr_n), .mc_out(mc_out)
  );

  function automatic logic f_next(logic [2:0] kind, logic q, logic a, logic b);
    case (kind)
      3'd1: return q ^ a;
      3'd2: return (a & b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
      3'd3: return (a & b) ? q : (a ? 1'b1 : (b ? 1'b0 : q));
      default: return a;
    endcase
  endfunction

  task automatic compare(string req, logic exp);
    n_chk++;
    if (mc_out !== exp) begin
      n_bad++;
      $display("FAIL %s: mc_out=%b expected=%b at %0t", req, mc_out, exp, $time);
    end
  endtask

  // called just after a negedge with inputs settled; ends at the next negedge
  task automatic step(string req);
    logic sum, src, tk, clr, exp;
    sum = (|pt_sum) ^ pt_pol;
    src = (cfg_clk_mode == 2'd2) ? pt_clk : (gclk[cfg_gclk_sel] ^ cfg_gclk_inv);
    tk  = src & ~r_prev & ((cfg_clk_mode != 2'd1) | gce);
    r_prev = src;
    clr = pt_clr | (cfg_gclr_en & ~gclr_n);
    if (clr)         r_q = 1'b0;
    else if (pt_pre) r_q = 1'b1;
    else if (tk)     r_q = f_next(cfg_ff_kind, r_q, sum, pt_k);
    exp = (cfg_ff_kind >= 3'd4) ? sum : (clr ? 1'b0 : (pt_pre ? 1'b1 : r_q));
    @(posedge clk); #1;
    compare(req, exp);
    @(negedge clk);
  endtask

  task automatic gpulse(string req);
    gclk = 2'b00; pt_clk = 1'b0; step(req);
    gclk = 2'b11; pt_clk = 1'b1; step(req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    r_q = 1'b0; r_prev = 1'b1;
    #2 rst_n = 1'b0;
    pt_sum = 5'b00001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    // R11: source already high at release gives no load
    step("R11"); step("R11");
    // R2: D load on a real edge, then 0
    gpulse("R2");
    pt_sum = 5'b00000; gpulse("R2");
    // R1: polarity inverts the OR, bypass is transparent
    pt_pol = 1'b1; gpulse("R1");
    cfg_ff_kind = 3'd4; pt_pol = 1'b0; pt_sum = 5'b10000; step("R1");
    pt_sum = 5'b00000; step("R1"); cfg_ff_kind = 3'd6; pt_pol = 1'b1; step("R1");
    // R1: register tracked underneath during bypass
    pt_pol = 1'b0; pt_sum = 5'b00100; gpulse("R1");
    cfg_ff_kind = 3'd0; pt_sum = 5'b0; step("R1");
    // R3: T
    cfg_ff_kind = 3'd1; pt_sum = 5'b00010; gpulse("R3"); gpulse("R3");
    pt_sum = 5'b0; gpulse("R3");
    // R4: JK all four combinations, toggle twice
    cfg_ff_kind = 3'd2;
    pt_sum = 5'b1; pt_k = 1'b0; gpulse("R4");
    pt_sum = 5'b1; pt_k = 1'b1; gpulse("R4"); gpulse("R4");
    pt_sum = 5'b0; pt_k = 1'b1; gpulse("R4");
    pt_sum = 5'b0; pt_k = 1'b0; gpulse("R4");
    // R5: SR both high holds
    cfg_ff_kind = 3'd3;
    pt_sum = 5'b1; pt_k = 1'b0; gpulse("R5");
    pt_sum = 5'b1; pt_k = 1'b1; gpulse("R5");
    pt_sum = 5'b0; pt_k = 1'b1; gpulse("R5"); gpulse("R5");
    // R6: enable low blocks, enable high passes, mode 3 acts as global
    cfg_ff_kind = 3'd0; cfg_clk_mode = 2'd1; gce = 1'b0; pt_k = 1'b0;
    pt_sum = 5'b1; gpulse("R6");
    gce = 1'b1; gpulse("R6");
    cfg_clk_mode = 2'd3; pt_sum = 5'b0; gpulse("R6");
    // R7: array clock, gce ignored, global clock ignored
    cfg_clk_mode = 2'd2; gce = 1'b0; pt_sum = 5'b1;
    pt_clk = 1'b0; gclk = 2'b00; step("R7");
    gclk = 2'b11; step("R7");
    pt_clk = 1'b1; step("R7");
    // R8: second clock inverted, falling pin edge loads
    cfg_clk_mode = 2'd0; cfg_gclk_sel = 1'b1; cfg_gclk_inv = 1'b1;
    pt_sum = 5'b0; gclk = 2'b10; step("R8");
    gclk = 2'b00; step("R8");
    gclk = 2'b01; step("R8");
    pt_sum = 5'b1; gclk = 2'b11; step("R8"); gclk = 2'b01; step("R8");
    // R9 / R10: immediate preset, clear, both, global clear gating
    cfg_gclk_inv = 1'b0; cfg_gclk_sel = 1'b0; gclk = 2'b11;
    pt_pre = 1'b1; step("R9"); pt_pre = 1'b0; step("R9");
    pt_clr = 1'b1; pt_pre = 1'b1; step("R10");
    pt_clr = 1'b0; step("R9");
    pt_pre = 1'b0; gclr_n = 1'b0; step("R10");
    gclr_n = 1'b1; pt_pre = 1'b1; step("R9"); pt_pre = 1'b0;
    cfg_gclr_en = 1'b0; gclr_n = 1'b0; step("R10"); gclr_n = 1'b1; cfg_gclr_en = 1'b1;

    // random mix
    for (int i = 0; i < 3000; i++) begin
      string tag;
      if (i % 40 == 0) begin
        cfg_ff_kind  = 3'($urandom_range(0, 7));
        cfg_clk_mode = 2'($urandom_range(0, 3));
        cfg_gclk_sel = 1'($urandom_range(0, 1));
        cfg_gclk_inv = 1'($urandom_range(0, 1));
        cfg_gclr_en  = 1'($urandom_range(0, 1));
      end
      pt_sum = ($urandom_range(0, 2) == 0) ? 5'($urandom) : 5'b0;
      pt_pol = 1'($urandom); pt_k = 1'($urandom);
      pt_clk = 1'($urandom); gclk = 2'($urandom); gce = 1'($urandom);
      pt_pre = ($urandom_range(0, 15) == 0);
      pt_clr = ($urandom_range(0, 15) == 0);
      gclr_n = ($urandom_range(0, 15) != 0);
      if (cfg_ff_kind >= 3'd4) tag = "R1";
      else if (pt_clr || (cfg_gclr_en && !gclr_n)) tag = "R10";
      else if (pt_pre) tag = "R9";
      else if (cfg_clk_mode == 2'd2) tag = "R7";
      else if (cfg_gclk_inv || cfg_gclk_sel) tag = "R8";
      else if (cfg_ff_kind == 3'd1) tag = "R3";
      else if (cfg_ff_kind == 3'd2) tag = "R4";
      else if (cfg_ff_kind == 3'd3) tag = "R5";
      else if (cfg_clk_mode == 2'd1) tag = "R6";
      else tag = "R2";
      step(tag);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule